// File: doc/BRIEF.md
# Floppy Wait-State Ready Generator

This block decides, every clock cycle, whether the host processor must be held off while it polls the floppy controller's data register. When the host reads or writes the trapped data address inside the controller window, software has armed the trap, and the drive motor is still spinning, the block pulls the host READY line low. The stall lasts until the floppy controller raises its data request (DRQ) or its completion interrupt (INTRQ), or until the motor stops. The host therefore moves one byte per access and needs no polling loop.

The block also holds the motor-on timer. This is a retriggerable one-shot built as a down-counter that is reloaded on each rising edge of a motor-kick bit. Its output drives four active-low spindle-motor enables together, and a force-ready signal toward the floppy controller. A parameter selects between two board-revision forms of the stall equation. The floppy controller is outside this block, and its DRQ and INTRQ lines arrive as inputs.

Top module: `disk_wait_ready`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ready` is 1, `motor_active` and `force_ready` are 0, and every bit of `drive_motor_n` is 1.
- R2: `ready` is 0 exactly when `ctrl_sel` is 1, `addr_low` equals 3'b110, the trap-enable bit is 1, `drq` is 0, `intrq` is 0 and `motor_active` is 1.
- R3: When `drq` is 1, `ready` is 1 in that same cycle, with no register delay.
- R4: When `intrq` is 1, `ready` is 1 in that same cycle.
- R5: With `ctrl_sel` at 0, or with `addr_low` at any value other than 3'b110 (odd values included), `ready` is 1.
- R6: A cycle with `trap_we` at 1 stores `trap_d` as the trap-enable bit, effective from the next cycle. The bit keeps its value while `trap_we` is 0. While the bit is 0, `ready` is 1.
- R7: A rising edge of `motor_kick` loads the timer with `MOTOR_TICKS`. `motor_active` is then 1 for exactly `MOTOR_TICKS` cycles, starting the cycle after the edge, and then returns to 0. While the motor is off, `ready` is 1.
- R8: A new rising edge of `motor_kick` while the timer runs reloads it to the full `MOTOR_TICKS`.
- R9: Holding `motor_kick` at 1 does not retrigger the timer. A level of 1 on `motor_kick` that is already present when reset is released does not start the timer.
- R10: `force_ready` equals `motor_active`, and every bit of `drive_motor_n` equals its inverse (active low, all drives together).
- R11: Both settings of the revision parameter give the same `ready` for every combination of inputs and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_sel | input | 1 | Floppy-controller register window is decoded |
| addr_low | input | 3 | Low host address bits |
| trap_we | input | 1 | Write strobe for the trap-enable bit |
| trap_d | input | 1 | Value written to the trap-enable bit |
| motor_kick | input | 1 | Motor control bit; a rising edge retriggers the timer |
| drq | input | 1 | Data request from the floppy controller |
| intrq | input | 1 | Completion interrupt from the floppy controller |
| ready | output | 1 | Host READY; 0 inserts wait states |
| motor_active | output | 1 | Motor timer output |
| force_ready | output | 1 | Force-ready toward the floppy controller |
| drive_motor_n | output | 4 | Spindle-motor enables, active low |

## Verification
The bench sets `MOTOR_TICKS` to 40 so that timeout, retrigger and held-level cases fit in a few dozen cycles. At the default the timer would run for a million cycles. It builds one instance of each board revision on shared inputs and compares their `ready` outputs at every check. This turns the claim that the two revisions are equivalent into an observed result across every stimulus row and directed case.

// File: rtl/disk_wait_pkg.sv
// Shared types and constants for the floppy wait-state ready generator.
// Assumes: the address field seen by the block is three bits wide.
package disk_wait_pkg;

    // Board revision: which form of the stall equation is built.
    typedef enum logic [0:0] {
        REV_FLAT  = 1'b0,   // single product term
        REV_SPLIT = 1'b1    // armed-trap term, then address gating
    } board_rev_e;

    localparam int LOW_W      = 3;
    localparam int NUM_DRIVES = 4;
    // Low address pattern of the trapped data register
    localparam logic [LOW_W-1:0] TRAP_ADDR = 3'b110;

endpackage

// File: rtl/disk_trap_reg.sv
// Trap-enable flag written by software.
// Assumes: a write strobe and its data arrive in the same cycle.
module disk_trap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic armed
);
    // Store the flag on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  armed <= 1'b0;
        else if (we) armed <= d;
    end
endmodule

// File: rtl/disk_motor_timer.sv
// Retriggerable motor-on one-shot built as a down-counter.
// A rising edge of the trigger reloads TICKS; the output is active while
// the count is nonzero. The trigger level that is present during reset is
// absorbed, so it does not start the timer.
// Assumes: TICKS >= 1.
module disk_motor_timer #(
    parameter int TICKS  = 1_000_000,
    parameter int DRIVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    output logic              active,
    output logic              force_rdy,
    output logic [DRIVES-1:0] motor_n
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);

    logic             trig_q;
    logic [CNT_W-1:0] count;
    logic             trig_rise;

    // Edge detect against the previous trigger level.
    assign trig_rise = trig && !trig_q;

    // Track the trigger level; during reset it follows the input.
    always_ff @(posedge clk) begin
        trig_q <= trig;
    end

    // Reload on an edge, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (trig_rise)         count <= LOAD;
        else if (count != '0)       count <= count - 1'b1;
    end

    assign active    = (count != '0);
    assign force_rdy = active;

    // One active-low enable per drive, all driven together.
    for (genvar g = 0; g < DRIVES; g++) begin : g_drv
        assign motor_n[g] = !active;
    end
endmodule

// File: rtl/disk_stall_logic.sv
// Combinational stall equation for the host READY line.
// REV picks one of two board-revision forms; both give the same result.
// Assumes: all inputs are settled within the cycle (no registers here).
module disk_stall_logic
    import disk_wait_pkg::*;
#(
    parameter board_rev_e REV = REV_FLAT
) (
    input  logic             sel,
    input  logic [LOW_W-1:0] addr,
    input  logic             trap,
    input  logic             motor,
    input  logic             drq,
    input  logic             intrq,
    output logic             stall
);
    if (REV == REV_FLAT) begin : g_flat
        // One product term over every wait condition.
        always_comb begin
            stall = sel && (addr == TRAP_ADDR) && trap && motor && !drq && !intrq;
        end
    end else begin : g_split
        logic armed_hit;
        // Board-level term: trap set, upper pair of address bits set, motor on.
        always_comb begin
            armed_hit = trap && (addr[2:1] == TRAP_ADDR[2:1]) && motor;
        end
        // Selector term: window decoded, even address, no byte, no interrupt.
        always_comb begin
            stall = sel && (addr[0] == TRAP_ADDR[0]) && armed_hit && !drq && !intrq;
        end
    end
endmodule

// File: rtl/disk_wait_ready.sv
// Top of the floppy wait-state ready generator: trap flag, motor timer and
// stall equation. READY is low only while the stall equation holds.
// Assumes: ctrl_sel is already decoded from the host address and card select.
module disk_wait_ready
    import disk_wait_pkg::*;
#(
    parameter board_rev_e REV         = REV_FLAT,
    parameter int         MOTOR_TICKS = 1_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_sel,
    input  logic [LOW_W-1:0]      addr_low,
    input  logic                  trap_we,
    input  logic                  trap_d,
    input  logic                  motor_kick,
    input  logic                  drq,
    input  logic                  intrq,
    output logic                  ready,
    output logic                  motor_active,
    output logic                  force_ready,
    output logic [NUM_DRIVES-1:0] drive_motor_n
);
    logic trap_en;
    logic stall;

    disk_trap_reg u_trap (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (trap_we),
        .d     (trap_d),
        .armed (trap_en)
    );

    disk_motor_timer #(
        .TICKS  (MOTOR_TICKS),
        .DRIVES (NUM_DRIVES)
    ) u_motor (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (motor_kick),
        .active    (motor_active),
        .force_rdy (force_ready),
        .motor_n   (drive_motor_n)
    );

    disk_stall_logic #(.REV(REV)) u_stall (
        .sel   (ctrl_sel),
        .addr  (addr_low),
        .trap  (trap_en),
        .motor (motor_active),
        .drq   (drq),
        .intrq (intrq),
        .stall (stall)
    );

    assign ready = !stall;
endmodule

// File: rtl/disk_wait_ready_chk.sv
// Property checker for disk_wait_ready, attached by bind.
module disk_wait_ready_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_sel,
    input logic [2:0] addr_low,
    input logic       motor_kick,
    input logic       drq,
    input logic       intrq,
    input logic       trap_en,
    input logic       ready,
    input logic       motor_active
);
    // R2: a stall implies every enabling condition
    a_r2_stall_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (ctrl_sel && addr_low == 3'b110 && trap_en && motor_active));

    // R3: data request releases the host
    a_r3_drq_releases: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> ready);

    // R4: completion interrupt releases the host
    a_r4_intrq_releases: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |-> ready);

    // R7: a trigger edge turns the motor on in the next cycle
    a_r7_kick_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motor_kick) |=> motor_active);

    // R9: without an edge, a stopped motor stays stopped
    a_r9_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!motor_active && !$rose(motor_kick)) |=> !motor_active);

    // R6: a cleared trap flag never stalls
    a_r6_trap_off_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en |-> ready);
endmodule

bind disk_wait_ready disk_wait_ready_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_sel     (ctrl_sel),
    .addr_low     (addr_low),
    .motor_kick   (motor_kick),
    .drq          (drq),
    .intrq        (intrq),
    .trap_en      (trap_en),
    .ready        (ready),
    .motor_active (motor_active)
);

// File: tb/disk_wait_ready_test.sv
module disk_wait_ready_test;
    import disk_wait_pkg::*;

    localparam int TICKS = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_sel = 1'b0;
    logic [2:0] addr_low = 3'b000;
    logic       trap_we = 1'b0;
    logic       trap_d = 1'b0;
    logic       motor_kick = 1'b0;
    logic       drq = 1'b0;
    logic       intrq = 1'b0;

    logic       ready, motor_active, force_ready;
    logic [3:0] drive_motor_n;
    logic       ready_b, motor_b, force_b;
    logic [3:0] drive_b;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = !clk;

    disk_wait_ready #(.REV(REV_FLAT), .MOTOR_TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_sel(ctrl_sel), .addr_low(addr_low),
        .trap_we(trap_we), .trap_d(trap_d), .motor_kick(motor_kick),
        .drq(drq), .intrq(intrq), .ready(ready), .motor_active(motor_active),
        .force_ready(force_ready), .drive_motor_n(drive_motor_n));

    disk_wait_ready #(.REV(REV_SPLIT), .MOTOR_TICKS(TICKS)) uut_rev (
        .clk(clk), .rst_n(rst_n), .ctrl_sel(ctrl_sel), .addr_low(addr_low),
        .trap_we(trap_we), .trap_d(trap_d), .motor_kick(motor_kick),
        .drq(drq), .intrq(intrq), .ready(ready_b), .motor_active(motor_b),
        .force_ready(force_b), .drive_motor_n(drive_b));

    // Stimulus rows {sel, addr[2:0], drq, intrq, expected ready}; trap set, motor on
    localparam logic [6:0] VEC [12] = '{
        7'b1_110_0_0_0,   // R2 full stall
        7'b1_110_1_0_1,   // R3 drq releases
        7'b1_110_0_1_1,   // R4 intrq releases
        7'b1_110_1_1_1,   // R3 R4 both
        7'b0_110_0_0_1,   // R5 window not selected
        7'b1_111_0_0_1,   // R5 odd address
        7'b1_010_0_0_1,   // R5
        7'b1_100_0_0_1,   // R5
        7'b1_000_0_0_1,   // R5
        7'b1_011_0_0_1,   // R5
        7'b1_101_0_0_1,   // R5
        7'b1_110_0_0_0    // R2 stall again
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Ready of both revisions against one expectation (R11 compares them)
    task automatic check_ready(input string tag, input logic exp);
        check(tag, {3'b0, ready}, {3'b0, exp});
        check({tag, " R11 revision match"}, {3'b0, ready_b}, {3'b0, exp});
    endtask

    task automatic motor_state(input string tag, input logic on);
        check({tag, " motor_active"}, {3'b0, motor_active}, {3'b0, on});
        check({tag, " R10 force_ready"}, {3'b0, force_ready}, {3'b0, on});
        check({tag, " R10 drive_motor_n"}, drive_motor_n, on ? 4'h0 : 4'hF);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R1: reset state, with stall-shaped inputs and trigger level held
        ctrl_sel = 1'b1; addr_low = 3'b110; motor_kick = 1'b1;
        repeat (3) step();
        check_ready("R1 reset ready", 1'b1);
        motor_state("R1 reset", 1'b0);
        rst_n = 1'b1;
        step();
        check_ready("R1 after reset ready", 1'b1);
        motor_state("R1 after reset", 1'b0);
        step();
        motor_state("R9 level at reset ignored", 1'b0);
        motor_kick = 1'b0;
        step();

        // Motor on, trap still clear: no stall (R6)
        motor_kick = 1'b1;
        step();
        motor_kick = 1'b0;
        motor_state("R7 motor started", 1'b1);
        check_ready("R6 trap clear ready", 1'b1);

        // Arm the trap (R6)
        trap_we = 1'b1; trap_d = 1'b1;
        step();
        trap_we = 1'b0; trap_d = 1'b0;
        check_ready("R6 trap set stalls", 1'b0);
        step();
        check_ready("R6 trap holds value", 1'b0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            {ctrl_sel, addr_low, drq, intrq} = VEC[i][6:1];
            #1;
            check_ready($sformatf("R2/R3/R4/R5 row %0d", i), VEC[i][0]);
            step();
        end
        drq = 1'b0; intrq = 1'b0; ctrl_sel = 1'b1; addr_low = 3'b110;

        // Clear trap, then re-arm (R6)
        trap_we = 1'b1; trap_d = 1'b0;
        step();
        trap_we = 1'b0;
        check_ready("R6 trap cleared ready", 1'b1);
        trap_we = 1'b1; trap_d = 1'b1;
        step();
        trap_we = 1'b0;

        // Let the motor run out, then a fresh timing run (R7)
        repeat (TICKS) step();
        motor_state("R7 expired", 1'b0);
        check_ready("R7 motor off ready", 1'b1);
        motor_kick = 1'b1;
        repeat (TICKS) step();
        motor_kick = 1'b0;
        motor_state("R7 last active cycle", 1'b1);
        check_ready("R2 stall while motor on", 1'b0);
        step();
        motor_state("R7 timeout", 1'b0);
        check_ready("R7 timeout ready", 1'b1);

        // Retrigger (R8): second edge 20 cycles after the first
        motor_kick = 1'b1;
        step();
        motor_kick = 1'b0;
        repeat (19) step();
        motor_kick = 1'b1;
        repeat (TICKS) step();
        motor_state("R8 extended by retrigger", 1'b1);
        step();
        motor_state("R8 retrigger expiry", 1'b0);

        // Held level (R9): trigger stays high
        motor_kick = 1'b0;
        step();
        motor_kick = 1'b1;
        repeat (TICKS) step();
        motor_state("R9 held level last cycle", 1'b1);
        step();
        motor_state("R9 held level no retrigger", 1'b0);
        motor_kick = 1'b0;
        step();

        report();
        $finish;
    end
endmodule